// File: doc/BRIEF.md
# Gated BCD Precession Frequency Counter

This block measures the frequency of a phase-locked oscillator whose feedback path divides by eighty. It owns that feedback divider: a mod-10 stage followed by a mod-8 stage. Each time the chain wraps, the block emits a one-clock reference pulse for the external phase detector. Because the loop forces the oscillator to eighty times the signal frequency, a short gate window can resolve the signal to 1 Hz or 0.1 Hz. The oscillator reaches the block as a single-cycle enable already synchronised to the system clock. The time base reaches it as a single-cycle tick.

A pulse marking the end of polarisation clears a chain of four BCD decades and opens the gate on the next clock. The gate stays open for a fixed number of time-base ticks, nominally one eighth of a second. While the gate is open, the decades count one of two sources. The coarse setting counts the output of the divide-by-10 stage. The fine setting counts every oscillator enable, and the thousands carry then falls off the top decade. When the gate closes, the four digits are copied into a display register and a ready pulse is raised. A manual clear input zeroes the running count without touching the display.

Top module: `gated_bcd_freq_counter`

## Requirements
- R1: While rst_ni is low, digits_o, gate_o, rdy_o and ref_o are all 0.
- R2: ref_o is high for exactly one clock after every 80th vco_en_i pulse counted since reset, and is low otherwise. The 80 comes from a divide-by-10 stage followed by a divide-by-8 stage.
- R3: With res_fine_i=0, the count advances once for every 10th vco_en_i pulse since reset (the divide-by-10 output). Those pulses are counted only at clock edges where gate_o is 1.
- R4: With res_fine_i=1, every vco_en_i pulse sampled at a clock edge where gate_o is 1 advances the count by one.
- R5: An end_pol_i pulse sets gate_o to 1 from the next clock. gate_o falls on the clock after the GATE_TICKS-th tick_i seen while it is open. A new end_pol_i while the gate is open restarts the window and its tick count. tick_i has no effect while the gate is closed.
- R6: end_pol_i zeroes the running count in the same edge, with priority over any increment.
- R7: digits_o holds four BCD nibbles, each in the range 0 to 9, with ones in bits [3:0], tens in [7:4], hundreds in [11:8] and thousands in [15:12]. Each nibble rolls over from 9 to 0 with a carry into the next. A carry out of the thousands digit is dropped, so the reading is the event count modulo 10000.
- R8: One clock after gate_o falls, digits_o takes the final count and rdy_o is high for that one clock. At all other times digits_o holds its value, even while clr_i, tick_i or vco_en_i is active.
- R9: clr_i zeroes the running count with priority over any increment. If it arrives mid-window, only the events after it are counted, and the gate timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| vco_en_i | input | 1 | One-cycle pulse per oscillator period |
| tick_i | input | 1 | One-cycle time-base tick |
| end_pol_i | input | 1 | End of polarisation: clear and open gate |
| clr_i | input | 1 | Manual clear of the running count |
| res_fine_i | input | 1 | 1: count raw oscillator (0.1 Hz); 0: count divide-by-10 (1 Hz) |
| ref_o | output | 1 | Divide-by-80 reference pulse for the phase detector |
| gate_o | output | 1 | Count window open |
| rdy_o | output | 1 | New reading latched |
| digits_o | output | 16 | Latched BCD reading, ones in the low nibble |

## Verification
A divider counter that slips by one phase shifts the spacing of ref_o within 80 oscillator pulses. In coarse mode it also changes which enables get counted. The stimulus feeds whole multiples of ten enables through each window, so a slip of that kind shows up as a wrong reading at the next latch. A fault in a decade or its carry shows up as an out-of-range nibble or a wrong digit in digits_o one clock after the gate closes. A fault in the gate timer shows on gate_o within a tick period, because gate_o is compared with a reference model on every clock.

// File: rtl/gbfc_pkg.sv
package gbfc_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t BCD_MAX = 4'd9;
endpackage

// File: rtl/gbfc_fb_divider.sv
module gbfc_fb_divider #(
  parameter int unsigned DIV_A = 10,
  parameter int unsigned DIV_B = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vco_en_i,
  output logic stage_a_o,
  output logic ref_o
);
  localparam int unsigned A_W = (DIV_A > 1) ? $clog2(DIV_A) : 1;
  localparam int unsigned B_W = (DIV_B > 1) ? $clog2(DIV_B) : 1;

  logic [A_W-1:0] cnt_a_q;
  logic [B_W-1:0] cnt_b_q;
  logic           a_last, b_last, ref_q;

  assign a_last    = (cnt_a_q == A_W'(DIV_A - 1));
  assign b_last    = (cnt_b_q == B_W'(DIV_B - 1));
  assign stage_a_o = vco_en_i & a_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_a_q <= '0;
      cnt_b_q <= '0;
      ref_q   <= 1'b0;
    end else begin
      if (vco_en_i) cnt_a_q <= a_last ? '0 : cnt_a_q + 1'b1;
      if (stage_a_o) cnt_b_q <= b_last ? '0 : cnt_b_q + 1'b1;
      ref_q <= stage_a_o & b_last;
    end
  end

  assign ref_o = ref_q;
endmodule

// File: rtl/gbfc_gate_timer.sv
module gbfc_gate_timer #(
  parameter int unsigned GATE_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic gate_o,
  output logic close_o
);
  localparam int unsigned T_W = $clog2(GATE_TICKS + 1);

  logic [T_W-1:0] tcnt_q;
  logic           gate_q, last;

  assign last    = (tcnt_q == T_W'(GATE_TICKS - 1));
  // restart wins over close
  assign close_o = gate_q & tick_i & last & ~start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      tcnt_q <= '0;
    end else if (start_i) begin
      gate_q <= 1'b1;
      tcnt_q <= '0;
    end else if (gate_q && tick_i) begin
      if (last) begin
        gate_q <= 1'b0;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/gbfc_bcd_chain.sv
module gbfc_bcd_chain
  import gbfc_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clr_i,
  input  logic                          inc_i,
  output logic [NUM_DIGITS*DIGIT_W-1:0] value_o
);
  logic [NUM_DIGITS-1:0] carry;
  assign carry[0] = inc_i;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dec
    bcd_t d_q;
    logic wrap;
    assign wrap = (d_q == BCD_MAX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       d_q <= '0;
      else if (clr_i)    d_q <= '0;
      else if (carry[i]) d_q <= wrap ? '0 : d_q + 1'b1;
    end

    // top decade carry is dropped
    if (i < NUM_DIGITS - 1) begin : g_c
      assign carry[i+1] = carry[i] & wrap;
    end

    assign value_o[i*DIGIT_W +: DIGIT_W] = d_q;
  end
endmodule

// File: rtl/gated_bcd_freq_counter.sv
module gated_bcd_freq_counter
  import gbfc_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned DIV_A      = 10,
  parameter int unsigned DIV_B      = 8,
  parameter int unsigned GATE_TICKS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          vco_en_i,
  input  logic                          tick_i,
  input  logic                          end_pol_i,
  input  logic                          clr_i,
  input  logic                          res_fine_i,
  output logic                          ref_o,
  output logic                          gate_o,
  output logic                          rdy_o,
  output logic [NUM_DIGITS*DIGIT_W-1:0] digits_o
);
  localparam int unsigned VAL_W = NUM_DIGITS * DIGIT_W;

  logic             stage_a, gate, close, cnt_src, close_q, rdy_q;
  logic [VAL_W-1:0] cnt_val, disp_q;

  gbfc_fb_divider #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vco_en_i (vco_en_i),
    .stage_a_o(stage_a),
    .ref_o    (ref_o)
  );

  gbfc_gate_timer #(.GATE_TICKS(GATE_TICKS)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(end_pol_i),
    .tick_i (tick_i),
    .gate_o (gate),
    .close_o(close)
  );

  assign cnt_src = res_fine_i ? vco_en_i : stage_a;

  gbfc_bcd_chain #(.NUM_DIGITS(NUM_DIGITS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (end_pol_i | clr_i),
    .inc_i  (gate & cnt_src),
    .value_o(cnt_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      close_q <= 1'b0;
      rdy_q   <= 1'b0;
      disp_q  <= '0;
    end else begin
      close_q <= close;
      rdy_q   <= close_q;
      if (close_q) disp_q <= cnt_val;
    end
  end

  assign gate_o   = gate;
  assign rdy_o    = rdy_q;
  assign digits_o = disp_q;
endmodule

// File: rtl/gated_bcd_freq_counter_chk.sv
module gated_bcd_freq_counter_chk #(
  parameter int unsigned NUM_DIGITS = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    end_pol_i,
  input logic                    clr_i,
  input logic                    ref_o,
  input logic                    gate_o,
  input logic                    rdy_o,
  input logic [NUM_DIGITS*4-1:0] digits_o,
  input logic [NUM_DIGITS*4-1:0] cnt_val
);
  function automatic logic all_bcd(input logic [NUM_DIGITS*4-1:0] v);
    logic ok = 1'b1;
    for (int i = 0; i < NUM_DIGITS; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (digits_o == '0 && !gate_o && !rdy_o && !ref_o));

  a_r2_ref_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_o |=> !ref_o);

  a_r5_gate_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_pol_i |=> gate_o);

  a_r6_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_pol_i |=> (cnt_val == '0));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_o && !end_pol_i && !clr_i) |=> $stable(cnt_val));

  a_r7_bcd_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_bcd(digits_o) && all_bcd(cnt_val));

  a_r8_rdy_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_o) |=> rdy_o);

  a_r8_display_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |-> $stable(digits_o));
endmodule

bind gated_bcd_freq_counter gated_bcd_freq_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .end_pol_i(end_pol_i),
  .clr_i    (clr_i),
  .ref_o    (ref_o),
  .gate_o   (gate_o),
  .rdy_o    (rdy_o),
  .digits_o (digits_o),
  .cnt_val  (cnt_val)
);

// File: tb/tb_gated_bcd_freq_counter.sv
module tb_gated_bcd_freq_counter;
  localparam int GT = 4;

  typedef struct packed {
    int p; int fine; int ts; int clr_at; int rs_at; int exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1, 1,  100,   0,   0, 400},  // R4
    '{3, 1,  300,   0,   0, 400},  // R4
    '{5, 1, 1000,   0,   0, 800},  // R4
    '{1, 0,  250,   0,   0, 100},  // R3
    '{2, 0,  500,   0,   0, 100},  // R3
    '{1, 1, 2600,   0,   0, 400},  // R7 overflow
    '{1, 1,  100, 250,   0, 150},  // R9 mid-window clear
    '{1, 1,  100,   0, 150, 350}   // R5 restart
  };

  logic clk = 0, rst_n = 0;
  logic vco = 0, tick = 0, endp = 0, clr = 0, fine = 0;
  logic ref_w, gate_w, rdy_w;
  logic [15:0] dig_w;

  int total = 0, bad = 0, track_err = 0;
  int m10 = 0, m8 = 0, tcnt = 0, count = 0, exp_disp = 0;
  bit exp_ref = 0, win = 0, closep = 0, exp_rdy = 0, saw_rdy = 0, done = 0;
  int vco_total = 0, ref_total = 0;

  always #2 clk = ~clk;

  gated_bcd_freq_counter #(.NUM_DIGITS(4), .DIV_A(10), .DIV_B(8), .GATE_TICKS(GT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .vco_en_i(vco), .tick_i(tick), .end_pol_i(endp),
    .clr_i(clr), .res_fine_i(fine), .ref_o(ref_w), .gate_o(gate_w), .rdy_o(rdy_w),
    .digits_o(dig_w)
  );

  function automatic logic [15:0] to_bcd(input int v);
    logic [15:0] r = '0;
    int x = v % 10000;
    for (int i = 0; i < 4; i++) begin
      r[i*4 +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare last edge against model, drive next inputs, advance model
  task automatic step(input bit v, input bit t, input bit e, input bit c);
    bit d10, src;
    @(negedge clk);
    if (ref_w !== exp_ref || gate_w !== win || rdy_w !== exp_rdy || dig_w !== to_bcd(exp_disp))
      track_err++;
    if (rdy_w) saw_rdy = 1;
    if (ref_w) ref_total++;
    vco = v; tick = t; endp = e; clr = c;
    if (v) vco_total++;
    d10 = v && (m10 == 9);
    exp_ref = d10 && (m8 == 7);
    if (v) m10 = (m10 == 9) ? 0 : m10 + 1;
    if (d10) m8 = (m8 == 7) ? 0 : m8 + 1;
    src = fine ? v : d10;
    exp_rdy = closep;
    if (closep) exp_disp = count;
    closep = 0;
    if (e) begin
      win = 1; tcnt = 0; count = 0;
    end else begin
      if (c) count = 0;
      else if (win && src) count = (count + 1) % 10000;
      if (win && t) begin
        if (tcnt == GT - 1) begin win = 0; tcnt = 0; closep = 1; end
        else tcnt++;
      end
    end
  endtask

  task automatic run_vec(input vec_t vv);
    int c = 0;
    fine = vv.fine[0];
    saw_rdy = 0;
    track_err = 0;
    step(0, 0, 1, 0);
    while (win || c == 0) begin
      c++;
      step((c % vv.p) == 0, (c % vv.ts) == 0, c == vv.rs_at, c == vv.clr_at);
    end
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0);
    check(dig_w === to_bcd(vv.exp), "R3 R4 R7 reading", int'(dig_w), int'(to_bcd(vv.exp)));
    check(saw_rdy, "R8 ready pulse", int'(saw_rdy), 1);
    check(track_err == 0, "R2 R5 R8 cycle tracking", track_err, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    check(dig_w == 0 && !gate_w && !rdy_w && !ref_w, "R1 reset state", int'(dig_w), 0);
    rst_n = 1;
    for (int i = 0; i < 8; i++) run_vec(VECS[i]);

    // R8: display holds, R5: ticks ignored while closed, R9 clear outside window
    held = dig_w;
    track_err = 0;
    for (int k = 0; k < 30; k++) step(1, k % 3 == 0, 0, k % 5 == 0);
    step(0, 0, 0, 0);
    check(dig_w === held, "R8 display hold", int'(dig_w), int'(held));
    check(!gate_w, "R5 tick ignored when closed", int'(gate_w), 0);
    check(track_err == 0, "R9 idle tracking", track_err, 0);

    // R2: reference pulse rate
    check(ref_total == vco_total / 80, "R2 divide by 80", ref_total, vco_total / 80);

    // R6: end_pol clears, a window with no events reads zero
    fine = 1;
    step(0, 0, 1, 0);
    for (int k = 1; k <= 4 * 50; k++) step(0, k % 50 == 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0);
    check(dig_w === 16'h0000, "R6 cleared on start", int'(dig_w), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule